// File: doc/BRIEF.md
# Lightweight Feistel Block Cipher Core

This core encrypts one block with a compact Feistel cipher. The word width W is a parameter and may be 16, 24 or 32 bits. The block is therefore 2W bits wide and the key is 4W bits wide. The core completes one full round per clock cycle on a W-bit datapath. It derives round keys on the fly: the key schedule reuses the same nonlinear word function as the data path and mixes in one constant bit per round from a small linear feedback shift register.

To use the core, present a plaintext and a key and pulse `start` while the core is idle. After the fixed number of rounds, `done` pulses for one cycle. The ciphertext then stays on `cipherText` until the next start is accepted. While a block is in flight, further start pulses are dropped.

Top module: `lwFeistelCore`

## Requirements
- R1: While `rstN` is low, `cipherText` reads all zeros and `done` reads 0.
- R2: The state has an upper word `hi` and a lower word `lo`. A start loads `plainText[2W-1:W]` into `hi` and `plainText[W-1:0]` into `lo`. In each round the core sets `hi <= lo ^ g(hi) ^ k` and `lo <= hi`, where `k` is the round key and `g(x) = (x & rotl(x,5)) ^ rotl(x,1)`. `cipherText` is `{hi, lo}`.
- R3: `done` goes high exactly ROUNDS clock edges after the edge that accepts `start`. ROUNDS is 32 for W=16, 36 for W=24 and 44 for W=32.
- R4: `done` is high for exactly one cycle per block.
- R5: After `done`, `cipherText` holds its value until the next start is accepted.
- R6: A `start` seen while a block is in flight has no effect on that block's result or timing.
- R7: The key state is four words `t0..t3`, loaded as `t_i = keyIn[i*W +: W]`. `t0` is the round key. Each round the words shift down (`t0 <= t1`, `t1 <= t2`, `t2 <= t3`) and `t3` takes `t0 ^ g(t1) ^ C ^ z`. C is `2^W - 4`, and z enters at bit 0.
- R8: The constant bit z is bit 0 of a shift register that is set to all ones on start and steps once per round. It shifts right, and the feedback enters the top bit. For W=16 and W=24 the register is 5 bits wide with feedback `s[0]^s[2]`. For W=32 it is 6 bits wide with feedback `s[0]^s[1]`.
- R9: A `start` presented in the same cycle that `done` is high is accepted and begins a new block.
- R10: All three word widths (16, 24, 32) meet R2 to R8 with their own round counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block (accepted only while idle) |
| plainText | input | 2W | Plaintext block, upper word first |
| keyIn | input | 4W | Key, lowest word is the first round key |
| cipherText | output | 2W | Current cipher state; final ciphertext after `done` |
| done | output | 1 | One-cycle pulse when the last round has completed |

## Verification
The all-zero plaintext with an all-zero key isolates the key-schedule constant and the shift-register bits, because only they can make the output nonzero. The all-ones block exercises the AND term of the word function at full density. Random plaintexts and keys at each of the three widths separate errors in rotation amounts, feedback taps and round counts. Three timing patterns are applied: a stray start mid-block, a start in the `done` cycle, and a long idle period after `done`. They tell apart faults in start acceptance, pulse width and output hold.

// File: rtl/lwFeistelPkg.sv
package lwFeistelPkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;  // capture plaintext, key and constant seed
    logic step;  // perform one round
  } pathCtrl_t;

  function automatic int roundsFor(input int word);
    return (word == 16) ? 32 : (word == 24) ? 36 : 44;
  endfunction

  function automatic int lfsrWidthFor(input int word);
    return (word == 32) ? 6 : 5;
  endfunction

endpackage

// File: rtl/lwFeistelCtrl.sv
module lwFeistelCtrl
  import lwFeistelPkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output pathCtrl_t strobes,
  output logic      done
);
  localparam int CNT_W = $clog2(ROUNDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  logic             busy;
  logic [CNT_W-1:0] roundIdx;

  assign strobes.load = start & ~busy;
  assign strobes.step = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      roundIdx <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobes.load) begin
        busy     <= 1'b1;
        roundIdx <= '0;
      end else if (busy) begin
        if (roundIdx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          roundIdx <= roundIdx + 1'b1;
        end
      end
    end
  end

  // R4: the completion pulse never lasts two cycles
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: completion follows only the final round
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(busy) && $past(roundIdx) == LAST));

  // R3: the round index advances by one per busy cycle
  assert_round_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && roundIdx != LAST) |=> (busy && roundIdx == $past(roundIdx) + 1'b1));

  // R6: a start while busy never restarts the count
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && roundIdx != '0 && roundIdx != LAST) |=> roundIdx != '0);

endmodule

// File: rtl/lwFeistelPath.sv
module lwFeistelPath
  import lwFeistelPkg::*;
#(
  parameter int WORD = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtrl_t         strobes,
  input  logic [2*WORD-1:0] plainText,
  input  logic [4*WORD-1:0] keyIn,
  output logic [2*WORD-1:0] cipherText
);
  localparam int LFSR_W = lfsrWidthFor(WORD);
  localparam int KEY_WORDS = 4;
  localparam logic [WORD-1:0] ROUND_CONST = ~WORD'(3);

  function automatic logic [WORD-1:0] mixWord(input logic [WORD-1:0] x);
    logic [WORD-1:0] r5, r1;
    r5 = {x[WORD-6:0], x[WORD-1:WORD-5]};
    r1 = {x[WORD-2:0], x[WORD-1]};
    return (x & r5) ^ r1;
  endfunction

  logic [WORD-1:0]   hiW, loW;
  logic [WORD-1:0]   keyW [KEY_WORDS];
  logic [LFSR_W-1:0] lfsr;
  logic              lfsrFb;
  logic [WORD-1:0]   keyNext, hiNext;

  generate
    if (LFSR_W == 6) begin : gTap6
      assign lfsrFb = lfsr[0] ^ lfsr[1];
    end else begin : gTap5
      assign lfsrFb = lfsr[0] ^ lfsr[2];
    end
  endgenerate

  assign hiNext  = loW ^ mixWord(hiW) ^ keyW[0];
  assign keyNext = keyW[0] ^ mixWord(keyW[1]) ^ ROUND_CONST
                   ^ {{(WORD-1){1'b0}}, lfsr[0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiW  <= '0;
      loW  <= '0;
      lfsr <= '1;
      for (int i = 0; i < KEY_WORDS; i++) keyW[i] <= '0;
    end else if (strobes.load) begin
      hiW  <= plainText[2*WORD-1:WORD];
      loW  <= plainText[WORD-1:0];
      lfsr <= '1;
      for (int i = 0; i < KEY_WORDS; i++) keyW[i] <= keyIn[i*WORD +: WORD];
    end else if (strobes.step) begin
      hiW  <= hiNext;
      loW  <= hiW;
      lfsr <= {lfsrFb, lfsr[LFSR_W-1:1]};
      for (int i = 0; i < KEY_WORDS - 1; i++) keyW[i] <= keyW[i+1];
      keyW[KEY_WORDS-1] <= keyNext;
    end
  end

  assign cipherText = {hiW, loW};

  // R2: the old upper word drops into the lower position each round
  assert_state_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load) |=> loW == $past(hiW));

  // R7: the key words move down one place per round
  assert_key_shift_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load) |=> (keyW[0] == $past(keyW[1]) && keyW[2] == $past(keyW[3])));

  // R5: without load or step the cipher state holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> ($stable(hiW) && $stable(loW)));

  // R8: the constant register restarts at all ones and never locks at zero
  assert_lfsr_seed_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> lfsr == '1);
  assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

endmodule

// File: rtl/lwFeistelCore.sv
module lwFeistelCore
  import lwFeistelPkg::*;
#(
  parameter int WORD = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2*WORD-1:0] plainText,
  input  logic [4*WORD-1:0] keyIn,
  output logic [2*WORD-1:0] cipherText,
  output logic              done
);
  localparam int ROUNDS = roundsFor(WORD);

  pathCtrl_t strobes;

  lwFeistelCtrl #(.ROUNDS(ROUNDS)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  lwFeistelPath #(.WORD(WORD)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .plainText  (plainText),
    .keyIn      (keyIn),
    .cipherText (cipherText)
  );

  // R1: outputs are quiet while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!done && cipherText == '0));

endmodule

// File: tb/lwFeistelCore_harness.sv
module lwFeistelCore_harness #(
  parameter int WORD = 16
) (
  input  logic clk,
  input  logic rstN,
  output int   checks,
  output int   fails,
  output logic finished
);
  localparam int ROUNDS = (WORD == 16) ? 32 : (WORD == 24) ? 36 : 44;
  localparam int LW  = (WORD == 32) ? 6 : 5;
  localparam int TAP = (WORD == 32) ? 1 : 2;
  localparam logic [WORD-1:0] KC = ~WORD'(3);

  logic              start;
  logic [2*WORD-1:0] plainText, cipherText;
  logic [4*WORD-1:0] keyIn;
  logic              done;

  lwFeistelCore #(.WORD(WORD)) u_lwFeistelCore (
    .clk(clk), .rstN(rstN), .start(start), .plainText(plainText),
    .keyIn(keyIn), .cipherText(cipherText), .done(done)
  );

  int seqChecks = 0, seqFails = 0, cycChecks = 0, cycFails = 0;
  assign checks = seqChecks + cycChecks;
  assign fails  = seqFails + cycFails;

  function automatic logic [WORD-1:0] rot(input logic [WORD-1:0] x, input int s);
    logic [WORD-1:0] y;
    for (int i = 0; i < WORD; i++) y[(i + s) % WORD] = x[i];
    return y;
  endfunction

  function automatic logic [WORD-1:0] gm(input logic [WORD-1:0] x);
    return (x & rot(x, 5)) ^ rot(x, 1);
  endfunction

  function automatic int lfsrStep(input int s);
    int fb;
    fb = (s ^ (s >> TAP)) & 1;
    return (s >> 1) | (fb << (LW - 1));
  endfunction

  function automatic logic [2*WORD-1:0] fullEncrypt(input logic [2*WORD-1:0] pt,
                                                    input logic [4*WORD-1:0] key);
    logic [WORD-1:0] k [4];
    logic [WORD-1:0] hi, lo, t, nk;
    int s;
    hi = pt[2*WORD-1:WORD];
    lo = pt[WORD-1:0];
    for (int i = 0; i < 4; i++) k[i] = key[i*WORD +: WORD];
    s = (1 << LW) - 1;
    for (int r = 0; r < ROUNDS; r++) begin
      t  = lo ^ gm(hi) ^ k[0];
      lo = hi;
      hi = t;
      nk = k[0] ^ gm(k[1]) ^ KC ^ WORD'(s & 1);
      k[0] = k[1]; k[1] = k[2]; k[2] = k[3]; k[3] = nk;
      s = lfsrStep(s);
    end
    return {hi, lo};
  endfunction

  // Cycle model: queue of key words, integer constant register.
  logic [WORD-1:0] mHi, mLo, mT, mNk;
  logic [WORD-1:0] mKey [$];
  int mLfsr, mLeft;
  bit mDone;

  always @(posedge clk) begin
    if (!rstN) begin
      mHi = '0; mLo = '0; mLeft = 0; mDone = 0; mKey.delete();
    end else begin
      mDone = 0;
      if (mLeft == 0 && start) begin
        mHi = plainText[2*WORD-1:WORD];
        mLo = plainText[WORD-1:0];
        mKey.delete();
        for (int i = 0; i < 4; i++) mKey.push_back(keyIn[i*WORD +: WORD]);
        mLfsr = (1 << LW) - 1;
        mLeft = ROUNDS;
      end else if (mLeft > 0) begin
        mT  = mLo ^ gm(mHi) ^ mKey[0];
        mLo = mHi;
        mHi = mT;
        mNk = mKey[0] ^ gm(mKey[1]) ^ KC ^ WORD'(mLfsr & 1);
        void'(mKey.pop_front());
        mKey.push_back(mNk);
        mLfsr = lfsrStep(mLfsr);
        mLeft--;
        if (mLeft == 0) mDone = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      cycChecks++;
      if (cipherText !== {mHi, mLo}) begin
        cycFails++;
        $display("FAIL R2 W=%0d cycle state act=%h exp=%h", WORD, cipherText, {mHi, mLo});
      end
      cycChecks++;
      if (done !== mDone) begin
        cycFails++;
        $display("FAIL R3 W=%0d done act=%0d exp=%0d", WORD, done, mDone);
      end
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [2*WORD-1:0] act, input logic [2*WORD-1:0] exp);
    seqChecks++;
    if (!ok) begin
      seqFails++;
      $display("FAIL %s W=%0d act=%h exp=%h", req, WORD, act, exp);
    end
  endtask

  task automatic runCase(input logic [2*WORD-1:0] pt, input logic [4*WORD-1:0] key,
                         input int strayAt, input bit checkHold, input string tag);
    int cyc;
    logic [2*WORD-1:0] exp;
    plainText = pt;
    keyIn     = key;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (done !== 1'b1 && cyc < ROUNDS + 10) begin
      if (strayAt != 0 && cyc == strayAt) begin
        start = 1'b1; plainText = ~pt; keyIn = ~key;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == ROUNDS + 1, {"R3 R10 latency ", tag}, (2*WORD)'(cyc), (2*WORD)'(ROUNDS + 1));
    exp = fullEncrypt(pt, key);
    chk(cipherText === exp, {"R2 R7 R8 result ", tag}, cipherText, exp);
    if (checkHold) begin
      @(negedge clk);
      chk(done === 1'b0, "R4 pulse width", (2*WORD)'(done), '0);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(cipherText === exp && done === 1'b0, "R5 hold", cipherText, exp);
      end
    end
  endtask

  function automatic logic [4*WORD-1:0] rndKey();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    finished  = 1'b0;
    start     = 1'b0;
    plainText = '0;
    keyIn     = '0;
    @(negedge clk);
    chk(cipherText === '0 && done === 1'b0, "R1 reset", cipherText, '0);
    wait (rstN === 1'b1);
    @(negedge clk);
    runCase('0, '0, 0, 1, "zero block zero key");
    runCase('1, '1, 0, 1, "all ones");
    for (int n = 0; n < 4; n++)
      runCase((2*WORD)'(rndKey()), rndKey(), 0, 1, "random");
    runCase((2*WORD)'(rndKey()), rndKey(), 3, 1, "R6 stray start");
    runCase((2*WORD)'(rndKey()), rndKey(), 0, 0, "chain first");
    runCase((2*WORD)'(rndKey()), rndKey(), 0, 1, "R9 start in done cycle");
    repeat (3) @(negedge clk);
    finished = 1'b1;
  end

endmodule

// File: tb/lwFeistelCore_bench.sv
module lwFeistelCore_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  int c16, f16, c24, f24, c32, f32;
  logic d16, d24, d32;

  // R10: one instance per legal word width
  lwFeistelCore_harness #(.WORD(16)) h16 (.clk(clk), .rstN(rstN), .checks(c16), .fails(f16), .finished(d16));
  lwFeistelCore_harness #(.WORD(24)) h24 (.clk(clk), .rstN(rstN), .checks(c24), .fails(f24), .finished(d24));
  lwFeistelCore_harness #(.WORD(32)) h32 (.clk(clk), .rstN(rstN), .checks(c32), .fails(f32), .finished(d32));

  initial begin
    int cyc;
    int wdChecks;
    int wdFails;
    wdChecks = 0;
    wdFails  = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
    while (!(d16 === 1'b1 && d24 === 1'b1 && d32 === 1'b1) && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    wdChecks = 1;
    if (!(d16 === 1'b1 && d24 === 1'b1 && d32 === 1'b1)) begin
      wdFails = 1;
      $display("FAIL R3 watchdog act=%0d exp=<%0d", cyc, 190000);
    end
    $display("TB_RESULT checks=%0d failures=%0d",
             c16 + c24 + c32 + wdChecks, f16 + f24 + f32 + wdFails);
    $finish;
  end
endmodule